// File: doc/BRIEF.md
# Carry-Switched Adder ALU

This block is a small combinational arithmetic and logic unit. Its datapath is a ripple chain of full-adder cells, one per operand bit. Each cell has a true/complement select on its B input, and the carry into each cell comes either from the cell below it or from a constant. Addition and subtraction use the chain in the usual way. Subtraction adds the complement of B with an initial carry of one.

The four logic functions need no extra gates. The carry chain is broken, every cell gets the same forced carry-in, and the result is read from either the sum outputs or the carry outputs of the cells:

| Forced carry-in | Sum output | Carry output |
|---|---|---|
| 0 | XOR | AND |
| 1 | XNOR | OR |

An equality flag is formed from the XNOR bits. The block has no clock and no state. Its outputs follow the operands and the operation select.

Top module: `csw_alu`

## Requirements
- R1: With op_sel = 3'b000 (add), {carry_out, result} equals op_a + op_b as an unsigned WIDTH+1-bit sum.
- R2: With op_sel = 3'b001 (subtract), result equals (op_a - op_b) mod 2^WIDTH. carry_out is 1 exactly when op_a >= op_b (no borrow).
- R3: With op_sel = 3'b010, result equals op_a AND op_b bitwise.
- R4: With op_sel = 3'b011, result equals op_a OR op_b bitwise.
- R5: With op_sel = 3'b100, result equals op_a XOR op_b bitwise.
- R6: With op_sel = 3'b101, result equals op_a XNOR op_b bitwise.
- R7: eq_flag is 1 exactly when op_sel = 3'b101 and op_a equals op_b. It is 0 under every other select code.
- R8: With op_sel = 3'b110 or 3'b111, result and carry_out are both 0.
- R9: carry_out is 0 in all four logic modes (select codes 3'b010 to 3'b101).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand; complemented inside the cells for subtract |
| op_sel | input | 3 | Operation code, as listed in the requirements |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry from the top cell in add and subtract; 0 otherwise |
| eq_flag | output | 1 | Operands equal; meaningful only in XNOR mode |

## Verification
The bench drives every operand pair under every one of the eight select codes, so it covers all carry-propagation lengths.

- A full-length ripple, such as 1111 + 0001, shows a broken carry link. It also shows a design that reads the forced constant where the chain should be.
- Subtract with A < B and with A = B exposes a missing initial carry or an inverted borrow sense on carry_out.
- In the logic modes, the bench catches a design that leaves the chain connected, because the result then picks up neighbouring bits. It also catches a design that taps sum where carry is wanted, because AND and XOR (or OR and XNOR) then swap.
- The unused codes and the equality flag under non-XNOR codes catch decode leaks.

// File: rtl/csw_alu_pkg.sv
package csw_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_XNOR = 3'd5
  } alu_op_e;

  typedef struct packed {
    logic b_inv;      // complement B in every cell
    logic ripple;     // carries chain from cell to cell
    logic cin_k;      // constant carry: bit 0 in ripple mode, all cells otherwise
    logic tap_carry;  // result taken from cell carries instead of sums
    logic valid;      // a defined operation code
    logic eq_mode;    // equality flag enabled
  } alu_ctrl_t;

endpackage

// File: rtl/csw_alu_decode.sv
module csw_alu_decode
  import csw_alu_pkg::*;
(
  input  logic [2:0] op_sel,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    case (alu_op_e'(op_sel))
      OP_ADD:  begin ctrl.ripple = 1'b1; ctrl.valid = 1'b1; end
      OP_SUB:  begin ctrl.ripple = 1'b1; ctrl.b_inv = 1'b1; ctrl.cin_k = 1'b1; ctrl.valid = 1'b1; end
      OP_AND:  begin ctrl.tap_carry = 1'b1; ctrl.valid = 1'b1; end
      OP_OR:   begin ctrl.tap_carry = 1'b1; ctrl.cin_k = 1'b1; ctrl.valid = 1'b1; end
      OP_XOR:  begin ctrl.valid = 1'b1; end
      OP_XNOR: begin ctrl.cin_k = 1'b1; ctrl.valid = 1'b1; ctrl.eq_mode = 1'b1; end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/csw_alu_cell.sv
module csw_alu_cell (
  input  logic a,
  input  logic b,
  input  logic b_inv,
  input  logic cin,
  output logic sum,
  output logic cout
);

  logic b_sel;
  logic half;

  // 2:1 true/complement select on the B leg
  assign b_sel = b_inv ? ~b : b;
  assign half  = a ^ b_sel;
  assign sum   = half ^ cin;
  assign cout  = (a & b_sel) | (half & cin);

endmodule

// File: rtl/csw_alu.sv
module csw_alu
  import csw_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             eq_flag
);

  localparam int unsigned MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] cell_cin;
  logic [WIDTH-1:0] cell_sum;
  logic [WIDTH-1:0] cell_cout;

  csw_alu_decode u_decode (
    .op_sel (op_sel),
    .ctrl   (ctrl)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign cell_cin[i] = ctrl.cin_k;
    end else begin : g_upper
      // carry switch: chain link or forced constant
      assign cell_cin[i] = ctrl.ripple ? cell_cout[i-1] : ctrl.cin_k;
    end

    csw_alu_cell u_cell (
      .a     (op_a[i]),
      .b     (op_b[i]),
      .b_inv (ctrl.b_inv),
      .cin   (cell_cin[i]),
      .sum   (cell_sum[i]),
      .cout  (cell_cout[i])
    );
  end

  always_comb begin
    if (!ctrl.valid)         result = '0;
    else if (ctrl.tap_carry) result = cell_cout;
    else                     result = cell_sum;
  end

  assign carry_out = ctrl.ripple & cell_cout[MSB];
  assign eq_flag   = ctrl.eq_mode & (&cell_sum);

  always_comb begin
    if (!$isunknown({op_a, op_b, op_sel})) begin
      if (op_sel == 3'd0)
        AST_ADD_SUM: assert ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b})); // R1
      if (op_sel == 3'd1)
        AST_SUB_DIFF: assert (result == WIDTH'(op_a - op_b) && carry_out == (op_a >= op_b)); // R2
      if (op_sel == 3'd2)
        AST_AND_BITS: assert (result == (op_a & op_b)); // R3
      if (op_sel == 3'd3)
        AST_OR_BITS: assert (result == (op_a | op_b)); // R4
      if (op_sel == 3'd4)
        AST_XOR_BITS: assert (result == (op_a ^ op_b)); // R5
      if (op_sel == 3'd5)
        AST_XNOR_BITS: assert (result == ~(op_a ^ op_b)); // R6
      AST_EQ_FLAG: assert (eq_flag == (op_sel == 3'd5 && op_a == op_b)); // R7
      if (op_sel > 3'd5)
        AST_UNUSED_ZERO: assert (result == '0 && !carry_out); // R8
      if (op_sel >= 3'd2 && op_sel <= 3'd5)
        AST_LOGIC_NO_CARRY: assert (!carry_out); // R9
    end
  end

endmodule

// File: tb/csw_alu_bench.sv
module csw_alu_bench;

  localparam int unsigned W = 4;
  localparam int unsigned NVAL = 1 << W;

  typedef struct {
    logic [2:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic         co;
    logic         eq;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic [2:0]   op_sel;
  logic [W-1:0] result;
  logic         carry_out;
  logic         eq_flag;

  int   n_tests;
  int   n_fail;
  logic done;
  exp_t q[$];

  csw_alu #(.WIDTH(W)) u_csw_alu (
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out),
    .eq_flag   (eq_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0:    return "R1";
      3'd1:    return "R2";
      3'd2:    return "R3/R9";
      3'd3:    return "R4/R9";
      3'd4:    return "R5/R9";
      3'd5:    return "R6/R7";
      default: return "R8";
    endcase
  endfunction

  function automatic exp_t model(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    logic [W:0] wide;
    e.op = op; e.a = a; e.b = b;
    e.res = '0; e.co = 1'b0; e.eq = 1'b0;
    case (op)
      3'd0: begin wide = {1'b0, a} + {1'b0, b}; e.res = wide[W-1:0]; e.co = wide[W]; end
      3'd1: begin e.res = a - b; e.co = (a >= b); end
      3'd2: e.res = a & b;
      3'd3: e.res = a | b;
      3'd4: e.res = a ^ b;
      3'd5: begin e.res = ~(a ^ b); e.eq = (a == b); end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b;
    q.push_back(model(op, a, b));
  endtask

  // monitor: compare on the rising edge, half a cycle after the drive
  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (result !== e.res || carry_out !== e.co || eq_flag !== e.eq) begin
        n_fail++;
        $display("FAIL %s op=%0d a=%h b=%h: got res=%h co=%b eq=%b, expected res=%h co=%b eq=%b",
                 req_of(e.op), e.op, e.a, e.b, result, carry_out, eq_flag, e.res, e.co, e.eq);
      end
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    op_sel = 3'd0; op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero operands under add give all-zero outputs (R1)
    n_tests++;
    if (result !== '0 || carry_out !== 1'b0 || eq_flag !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset state: got res=%h co=%b eq=%b, expected 0 0 0", result, carry_out, eq_flag);
    end
    rst_n = 1'b1;
    // named corners first: full ripple, borrow, equal operands
    drive(3'd0, 4'hF, 4'h1);
    drive(3'd1, 4'h3, 4'h5);
    drive(3'd1, 4'h7, 4'h7);
    drive(3'd5, 4'hA, 4'hA);
    drive(3'd2, 4'hC, 4'hA);
    drive(3'd3, 4'hC, 4'hA);
    drive(3'd6, 4'hF, 4'hF);
    // exhaustive sweep over every code and operand pair
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < NVAL; a++)
        for (int b = 0; b < NVAL; b++)
          drive(3'(op), W'(a), W'(b));
    @(negedge clk);
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected run to finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule